// File: doc/BRIEF.md
# Two-Bank Data Register File with Shared Window

This block holds the data memory of a small 8-bit microcontroller core. The instruction supplies a 7-bit direct address and the status register supplies one bank bit. The block joins them into an 8-bit effective address, `{bank_sel, addr}`, and sorts that address into one of three regions: the special function register window, general purpose RAM, or unimplemented space. Bank 0 holds 64 bytes of RAM at 40h–7Fh. The top sixteen bytes of that RAM (70h–7Fh) are also reached from bank 1 at F0h–FFh. Every other location outside the special function register window holds no storage and reads as zero.

There is one combinational read port and one write port. The bank bit is shared by both ports. When an address falls in the special function register window, the block raises a select strobe for an external register block and leaves its own RAM untouched. The core muxes in the external data in that case. All pins are plain control and data wires. An access completes in the cycle it is presented, so no handshake or back-pressure is involved.

Top module: `bank_regfile`

## Requirements
- R1: A read whose 7-bit address is below 20h, in either bank, raises `sfr_rd_sel` and drives `rd_data` to zero. For any other read address, `sfr_rd_sel` is low.
- R2: A write (`wr_en` high) whose address is below 20h raises `sfr_wr_sel` in that cycle and changes no RAM byte. `sfr_wr_sel` is low whenever `wr_en` is low.
- R3: With `bank_sel` = 0, addresses 40h–7Fh read back the byte last written to them.
- R4: With `bank_sel` = 1, addresses 70h–7Fh (effective F0h–FFh) reach the same bytes as 70h–7Fh in bank 0, for both reads and writes.
- R5: Reads of unimplemented locations return zero. These are bank 0 addresses 20h–3Fh and bank 1 addresses 20h–6Fh (effective A0h–EFh).
- R6: Writes to unimplemented locations change no storage. For example, a write to bank 1 address 45h leaves bank 0 address 45h unchanged.
- R7: Reads are combinational. A write committed at a clock edge is visible on `rd_data` for the same location in the next cycle.
- R8: After reset, every RAM byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low reset; clears all RAM bytes |
| bank_sel | input | 1 | Bank bit from the status register, shared by both ports |
| rd_addr | input | 7 | Direct read address |
| rd_data | output | 8 | Read data; zero in the SFR window and in unimplemented space |
| sfr_rd_sel | output | 1 | Read address lies in the SFR window |
| wr_en | input | 1 | Write request |
| wr_addr | input | 7 | Direct write address |
| wr_data | input | 8 | Write data |
| sfr_wr_sel | output | 1 | Write request targets the SFR window |

## Verification
The bench builds the block with its default parameters: an 8-bit data width, a 7-bit address, the SFR window ending at 20h, RAM starting at 40h, and the shared window starting at 70h. At these values every region edge can be probed directly: 1Fh/20h, 3Fh/40h and 6Fh/70h in both banks, and 7Fh at the top. Writes through the bank 1 window are read back through bank 0. Writes into the unimplemented hole of bank 1 are checked against the bank 0 byte that shares the same low address bits. This exposes any decode that drops the bank bit.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

  typedef enum logic [1:0] {
    RGN_SFR  = 2'd0,
    RGN_GPR  = 2'd1,
    RGN_NONE = 2'd2
  } region_e;

endpackage

// File: rtl/bank_rf_decode.sv
module bank_rf_decode
  import bank_rf_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SFR_TOP     = 32,
  parameter int GPR_BASE    = 64,
  parameter int SHARED_BASE = 112
) (
  input  logic [ADDR_W:0]   eff_addr,
  output region_e           region,
  output logic [ADDR_W-1:0] ram_idx
);

  logic              bank;
  logic [ADDR_W-1:0] low;

  assign bank = eff_addr[ADDR_W];
  assign low  = eff_addr[ADDR_W-1:0];

  // The shared window maps onto bank 0 storage through the low bits alone.
  assign ram_idx = low;

  always_comb begin
    if (int'(low) < SFR_TOP) begin
      region = RGN_SFR;
    end else if (!bank && int'(low) >= GPR_BASE) begin
      region = RGN_GPR;
    end else if (bank && int'(low) >= SHARED_BASE) begin
      region = RGN_GPR;
    end else begin
      region = RGN_NONE;
    end
  end

endmodule

// File: rtl/bank_rf_store.sv
module bank_rf_store #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 7,
  parameter int GPR_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] ridx,
  output logic [DATA_W-1:0] rdata
);

  localparam int SPAN = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [GPR_BASE:SPAN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = GPR_BASE; i < SPAN; i++) begin
        mem[i] <= '0;
      end
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  // Out-of-range indices are masked by the caller's region check.
  always_comb begin
    if (int'(ridx) >= GPR_BASE) begin
      rdata = mem[ridx];
    end else begin
      rdata = '0;
    end
  end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_rf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SFR_TOP     = 32,
  parameter int GPR_BASE    = 64,
  parameter int SHARED_BASE = 112
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sfr_rd_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sfr_wr_sel
);

  localparam int PORTS = 2;

  logic [ADDR_W:0]   eff     [PORTS];
  region_e           rgn     [PORTS];
  logic [ADDR_W-1:0] idx     [PORTS];
  logic [DATA_W-1:0] store_q;
  logic              ram_we;

  assign eff[0] = {bank_sel, rd_addr};
  assign eff[1] = {bank_sel, wr_addr};

  for (genvar p = 0; p < PORTS; p++) begin : g_dec
    bank_rf_decode #(
      .ADDR_W      (ADDR_W),
      .SFR_TOP     (SFR_TOP),
      .GPR_BASE    (GPR_BASE),
      .SHARED_BASE (SHARED_BASE)
    ) u_dec (
      .eff_addr (eff[p]),
      .region   (rgn[p]),
      .ram_idx  (idx[p])
    );
  end

  assign ram_we     = wr_en && (rgn[1] == RGN_GPR);
  assign sfr_wr_sel = wr_en && (rgn[1] == RGN_SFR);
  assign sfr_rd_sel = (rgn[0] == RGN_SFR);

  bank_rf_store #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .GPR_BASE (GPR_BASE)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .widx  (idx[1]),
    .wdata (wr_data),
    .ridx  (idx[0]),
    .rdata (store_q)
  );

  assign rd_data = (rgn[0] == RGN_GPR) ? store_q : '0;

endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SFR_TOP     = 32,
  parameter int GPR_BASE    = 64,
  parameter int SHARED_BASE = 112
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_sel,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              sfr_rd_sel,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              sfr_wr_sel
);

  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R1
  sfr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) < SFR_TOP) |-> (sfr_rd_sel && rd_data == '0));

  // R1
  sfr_rd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) >= SFR_TOP) |-> !sfr_rd_sel);

  // R2
  sfr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) < SFR_TOP) |-> sfr_wr_sel);

  // R2
  sfr_wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !sfr_wr_sel);

  // R5
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) >= SFR_TOP &&
     ((!bank_sel && int'(rd_addr) < GPR_BASE) ||
      (bank_sel && int'(rd_addr) < SHARED_BASE))) |-> (rd_data == '0));

  // R7
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wr_en) && $past(bank_sel) == bank_sel &&
     $past(wr_addr) == rd_addr &&
     ((!bank_sel && int'(rd_addr) >= GPR_BASE) ||
      (bank_sel && int'(rd_addr) >= SHARED_BASE)))
    |-> (rd_data == $past(wr_data)));

  // R4
  shared_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wr_en) && $past(bank_sel) && !bank_sel &&
     int'($past(wr_addr)) >= SHARED_BASE && $past(wr_addr) == rd_addr)
    |-> (rd_data == $past(wr_data)));

endmodule

bind bank_regfile bank_regfile_chk #(
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W),
  .SFR_TOP     (SFR_TOP),
  .GPR_BASE    (GPR_BASE),
  .SHARED_BASE (SHARED_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bank_sel   (bank_sel),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .sfr_rd_sel (sfr_rd_sel),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .sfr_wr_sel (sfr_wr_sel)
);

// File: tb/bank_regfile_bench.sv
`timescale 1ns/1ps
module bank_regfile_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_sel = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sfr_rd_sel;
  logic       wr_en = 1'b0;
  logic [6:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sfr_wr_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bank_regfile u_bank_regfile (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_sel   (bank_sel),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .sfr_rd_sel (sfr_rd_sel),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sfr_wr_sel (sfr_wr_sel)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input bit b, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bank_sel = b; wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_byte(input bit b, input logic [6:0] a, output logic [7:0] d);
    bank_sel = b; rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 64; a < 128; a += 21) begin
      read_byte(1'b0, 7'(a), v);
      check("R8 reset clear", v, 0);
    end
    read_byte(1'b0, 7'h7f, v);
    check("R8 reset clear top", v, 0);
  endtask

  task automatic t_sfr_window();
    logic [7:0] v;
    write_byte(1'b0, 7'h50, 8'h77);
    read_byte(1'b0, 7'h1f, v);
    check("R1 sfr sel b0 1Fh", sfr_rd_sel, 1);
    check("R1 sfr data b0 1Fh", v, 0);
    read_byte(1'b1, 7'h00, v);
    check("R1 sfr sel b1 00h", sfr_rd_sel, 1);
    read_byte(1'b0, 7'h20, v);
    check("R1 sfr sel off 20h", sfr_rd_sel, 0);
    @(negedge clk);
    bank_sel = 1'b0; wr_addr = 7'h10; wr_data = 8'hAA; wr_en = 1'b1;
    #1;
    check("R2 sfr_wr_sel high", sfr_wr_sel, 1);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R2 sfr_wr_sel idle", sfr_wr_sel, 0);
    read_byte(1'b0, 7'h50, v);
    check("R2 ram untouched", v, 8'h77);
    read_byte(1'b0, 7'h10, v);
    check("R2 sfr read zero", v, 0);
  endtask

  task automatic t_bank0_gpr();
    logic [7:0] v;
    write_byte(1'b0, 7'h40, 8'h11);
    write_byte(1'b0, 7'h6f, 8'h22);
    write_byte(1'b0, 7'h7f, 8'h33);
    read_byte(1'b0, 7'h40, v); check("R3 40h", v, 8'h11);
    read_byte(1'b0, 7'h6f, v); check("R3 6Fh", v, 8'h22);
    read_byte(1'b0, 7'h7f, v); check("R3 7Fh", v, 8'h33);
  endtask

  task automatic t_shared();
    logic [7:0] v;
    write_byte(1'b1, 7'h70, 8'hC3);
    read_byte(1'b0, 7'h70, v); check("R4 b1 write seen in b0 70h", v, 8'hC3);
    write_byte(1'b0, 7'h7e, 8'h5A);
    read_byte(1'b1, 7'h7e, v); check("R4 b0 write seen in b1 FEh", v, 8'h5A);
    read_byte(1'b1, 7'h7f, v); check("R4 b1 FFh", v, 8'h33);
  endtask

  task automatic t_holes();
    logic [7:0] v;
    read_byte(1'b0, 7'h20, v); check("R5 b0 20h", v, 0);
    read_byte(1'b0, 7'h3f, v); check("R5 b0 3Fh", v, 0);
    read_byte(1'b1, 7'h40, v); check("R5 b1 C0h", v, 0);
    read_byte(1'b1, 7'h6f, v); check("R5 b1 EFh", v, 0);
  endtask

  task automatic t_hole_writes();
    logic [7:0] v;
    write_byte(1'b0, 7'h45, 8'h99);
    write_byte(1'b1, 7'h45, 8'h01);
    read_byte(1'b0, 7'h45, v); check("R6 b0 45h unchanged", v, 8'h99);
    write_byte(1'b1, 7'h6f, 8'hEE);
    read_byte(1'b0, 7'h6f, v); check("R6 b0 6Fh unchanged", v, 8'h22);
    write_byte(1'b0, 7'h30, 8'hEE);
    read_byte(1'b0, 7'h30, v); check("R6 b0 30h still zero", v, 0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    bank_sel = 1'b0; rd_addr = 7'h55;
    wr_addr = 7'h55; wr_data = 8'h3C; wr_en = 1'b1;
    #1;
    check("R7 old value before edge", rd_data, 0);
    @(negedge clk);
    wr_data = 8'h4D;
    #1;
    check("R7 new value next cycle", rd_data, 8'h3C);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R7 second back-to-back value", rd_data, 8'h4D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sfr_window();
    t_bank0_gpr();
    t_shared();
    t_holes();
    t_hole_writes();
    t_back_to_back();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule